// File: doc/BRIEF.md
# Speculative Store Side Cache

This block is a tiny direct-mapped store buffer that a processor core uses while it executes speculatively past a long-latency load miss. During that speculative period stores must not reach real memory. Instead they are written into this side cache. Later speculative loads can then pick up the stored values. Each entry holds a tag, one data word and a poison flag. The poison flag records that the stored value depends on data that is not yet known.

A load probes this cache in the same cycle as the normal data cache. When the probe hits, the block's word and poison flag replace the data cache response. On a miss, the data cache word passes through unpoisoned. There is no path to the memory hierarchy, so a store that lands on an occupied entry overwrites it and the old contents are lost. A flush pulse, raised when speculation ends, empties every entry.

Top module: `spec_store_cache`

## Requirements
- R1: After reset every entry is empty, so a speculative load misses and `ld_data` equals `dc_data` with `ld_poison` low.
- R2: While `ahead_mode` is low, stores write nothing and loads never hit. `ld_data` follows `dc_data` and `ld_poison` is low.
- R3: A speculative store (`ahead_mode`=1, `st_en`=1, `flush`=0) makes a later speculative load of the same word hit and return the stored word.
- R4: A store with `st_poison`=1 leaves its entry poisoned, so a load that hits the entry reports `ld_poison`=1.
- R5: A store with `st_poison`=0 to a poisoned word clears the poison flag.
- R6: On a hit, `ld_hit`=1 and the cached word replaces `dc_data`. On a miss, `ld_hit`=0, `ld_data`=`dc_data` and `ld_poison`=0.
- R7: A store whose index matches an occupied entry but whose tag differs replaces that entry. After that, a load of the old word misses.
- R8: `flush` empties every entry at the next clock edge. A store presented in the flush cycle is dropped and is not forwarded.
- R9: A load of the same word that an accepted store presents in the same cycle hits and returns that store's data and poison flag.
- R10: Addresses are byte addresses. Bits [1:0] select a byte and are ignored. Bits [5:2] select one of 16 entries. Bits [31:6] form the tag.
- R11: When `ld_en` is low, `ld_hit` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ahead_mode | input | 1 | High while the core executes speculatively |
| flush | input | 1 | Pulse that empties all entries when speculation ends |
| st_en | input | 1 | Store request valid |
| st_addr | input | 32 | Store byte address |
| st_data | input | 32 | Store data word |
| st_poison | input | 1 | Store data depends on unknown values |
| ld_en | input | 1 | Load probe valid |
| ld_addr | input | 32 | Load byte address |
| dc_data | input | 32 | Word returned by the normal data cache for this load |
| ld_hit | output | 1 | Probe hit; the cached word overrides the data cache word |
| ld_data | output | 32 | Merged load word |
| ld_poison | output | 1 | Merged load word is poisoned |

## Verification
The assertions assume that the store and load inputs are steady for the whole cycle around each rising edge. They also assume that `st_en` and `ahead_mode` are low while reset is active, because the store-visibility property looks one cycle back. The bench changes every input only on the falling clock edge and keeps all requests low through reset. It samples the combinational load outputs one nanosecond later, before the edge that commits a store.

// File: rtl/ssc_pkg.sv
package ssc_pkg;
  localparam int unsigned SSC_ADDR_W = 32;
  localparam int unsigned SSC_DATA_W = 32;
  localparam int unsigned SSC_LINES  = 16;
endpackage

// File: rtl/ssc_line_array.sv
module ssc_line_array #(
  parameter int unsigned LINES  = ssc_pkg::SSC_LINES,
  parameter int unsigned TAG_W  = 26,
  parameter int unsigned DATA_W = ssc_pkg::SSC_DATA_W,
  localparam int unsigned IDX_W = $clog2(LINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              clr_all,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_poison,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              rd_valid,
  output logic [TAG_W-1:0]  rd_tag,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_poison
);
  logic [LINES-1:0]  valid_q;
  logic [LINES-1:0]  valid_d;
  logic [TAG_W-1:0]  tag_q    [LINES];
  logic [DATA_W-1:0] data_q   [LINES];
  logic              poison_q [LINES];

  // Per-entry next state: clear wins over a write
  for (genvar g = 0; g < LINES; g++) begin : g_line
    assign valid_d[g] = clr_all ? 1'b0
                      : ((wr_en && (wr_idx == IDX_W'(g))) ? 1'b1 : valid_q[g]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
    end else begin
      valid_q <= valid_d;
    end
  end

  // Payload needs no reset; it is qualified by valid_q
  always_ff @(posedge clk) begin
    if (wr_en && !clr_all) begin
      tag_q[wr_idx]    <= wr_tag;
      data_q[wr_idx]   <= wr_data;
      poison_q[wr_idx] <= wr_poison;
    end
  end

  assign rd_valid  = valid_q[rd_idx];
  assign rd_tag    = tag_q[rd_idx];
  assign rd_data   = data_q[rd_idx];
  assign rd_poison = poison_q[rd_idx];
endmodule

// File: rtl/ssc_lookup.sv
module ssc_lookup #(
  parameter int unsigned TAG_W  = 26,
  parameter int unsigned DATA_W = ssc_pkg::SSC_DATA_W
) (
  input  logic              probe_en,
  input  logic [TAG_W-1:0]  probe_tag,
  input  logic              ent_valid,
  input  logic [TAG_W-1:0]  ent_tag,
  input  logic [DATA_W-1:0] ent_data,
  input  logic              ent_poison,
  input  logic              byp_en,
  input  logic [DATA_W-1:0] byp_data,
  input  logic              byp_poison,
  output logic              hit,
  output logic [DATA_W-1:0] hit_data,
  output logic              hit_poison
);
  logic stored_match;

  always_comb begin
    stored_match = ent_valid && (ent_tag == probe_tag);
    hit          = probe_en && (byp_en || stored_match);
    if (byp_en) begin
      hit_data   = byp_data;
      hit_poison = byp_poison;
    end else begin
      hit_data   = ent_data;
      hit_poison = ent_poison;
    end
  end
endmodule

// File: rtl/ssc_merge.sv
module ssc_merge #(
  parameter int unsigned DATA_W = ssc_pkg::SSC_DATA_W
) (
  input  logic              hit,
  input  logic [DATA_W-1:0] loc_data,
  input  logic              loc_poison,
  input  logic [DATA_W-1:0] dc_data,
  output logic [DATA_W-1:0] out_data,
  output logic              out_poison
);
  always_comb begin
    if (hit) begin
      out_data   = loc_data;
      out_poison = loc_poison;
    end else begin
      out_data   = dc_data;
      out_poison = 1'b0;
    end
  end
endmodule

// File: rtl/spec_store_cache.sv
module spec_store_cache #(
  parameter int unsigned ADDR_W = ssc_pkg::SSC_ADDR_W,
  parameter int unsigned DATA_W = ssc_pkg::SSC_DATA_W,
  parameter int unsigned LINES  = ssc_pkg::SSC_LINES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ahead_mode,
  input  logic              flush,
  input  logic              st_en,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic [DATA_W-1:0] st_data,
  input  logic              st_poison,
  input  logic              ld_en,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [DATA_W-1:0] dc_data,
  output logic              ld_hit,
  output logic [DATA_W-1:0] ld_data,
  output logic              ld_poison
);
  localparam int unsigned OFF_W = $clog2(DATA_W / 8);
  localparam int unsigned IDX_W = $clog2(LINES);
  localparam int unsigned TAG_W = ADDR_W - IDX_W - OFF_W;

  logic [IDX_W-1:0]  st_idx, ld_idx;
  logic [TAG_W-1:0]  st_tag, ld_tag;
  logic              st_accept, probe_en, byp_en;
  logic              ent_valid, ent_poison;
  logic [TAG_W-1:0]  ent_tag;
  logic [DATA_W-1:0] ent_data;
  logic              loc_hit, loc_poison;
  logic [DATA_W-1:0] loc_data;
  logic              unused_offset_bits;

  always_comb begin
    st_idx    = st_addr[OFF_W +: IDX_W];
    ld_idx    = ld_addr[OFF_W +: IDX_W];
    st_tag    = st_addr[ADDR_W-1 -: TAG_W];
    ld_tag    = ld_addr[ADDR_W-1 -: TAG_W];
    st_accept = ahead_mode && st_en && !flush;
    probe_en  = ahead_mode && ld_en;
    byp_en    = st_accept && (st_idx == ld_idx) && (st_tag == ld_tag);
  end

  assign unused_offset_bits = ^{st_addr[OFF_W-1:0], ld_addr[OFF_W-1:0]};

  ssc_line_array #(.LINES(LINES), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_lines (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (st_accept),
    .clr_all   (flush),
    .wr_idx    (st_idx),
    .wr_tag    (st_tag),
    .wr_data   (st_data),
    .wr_poison (st_poison),
    .rd_idx    (ld_idx),
    .rd_valid  (ent_valid),
    .rd_tag    (ent_tag),
    .rd_data   (ent_data),
    .rd_poison (ent_poison)
  );

  ssc_lookup #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_lookup (
    .probe_en   (probe_en),
    .probe_tag  (ld_tag),
    .ent_valid  (ent_valid),
    .ent_tag    (ent_tag),
    .ent_data   (ent_data),
    .ent_poison (ent_poison),
    .byp_en     (byp_en),
    .byp_data   (st_data),
    .byp_poison (st_poison),
    .hit        (loc_hit),
    .hit_data   (loc_data),
    .hit_poison (loc_poison)
  );

  ssc_merge #(.DATA_W(DATA_W)) u_merge (
    .hit        (loc_hit),
    .loc_data   (loc_data),
    .loc_poison (loc_poison),
    .dc_data    (dc_data),
    .out_data   (ld_data),
    .out_poison (ld_poison)
  );

  assign ld_hit = loc_hit;
endmodule

// File: rtl/ssc_checker.sv
module ssc_checker #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned LINES  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ahead_mode,
  input logic              flush,
  input logic              st_en,
  input logic [ADDR_W-1:0] st_addr,
  input logic [DATA_W-1:0] st_data,
  input logic              st_poison,
  input logic              ld_en,
  input logic [ADDR_W-1:0] ld_addr,
  input logic [DATA_W-1:0] dc_data,
  input logic              ld_hit,
  input logic [DATA_W-1:0] ld_data,
  input logic              ld_poison
);
  localparam int unsigned OFF_W = $clog2(DATA_W / 8);
  localparam int unsigned WRD_W = ADDR_W - OFF_W;

  logic [WRD_W-1:0] st_word, ld_word;
  logic             st_take, same_word;
  assign st_word   = st_addr[ADDR_W-1:OFF_W];
  assign ld_word   = ld_addr[ADDR_W-1:OFF_W];
  assign st_take   = ahead_mode && st_en && !flush;
  assign same_word = (st_word == ld_word);

  AST_NORMAL_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    !ahead_mode |-> !ld_hit); // R2

  AST_IDLE_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_en |-> !ld_hit); // R11

  AST_MISS_PASSTHRU: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_hit |-> (ld_data == dc_data) && !ld_poison); // R6

  AST_SAME_CYCLE_FWD: assert property (@(posedge clk) disable iff (!rst_n)
    (st_take && ld_en && same_word) |-> ld_hit && (ld_data == st_data) && (ld_poison == st_poison)); // R9

  AST_STORE_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    (ahead_mode && ld_en && !(st_en && same_word) && $past(st_take) && (ld_word == $past(st_word)))
      |-> ld_hit && (ld_data == $past(st_data)) && (ld_poison == $past(st_poison))); // R3

  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (!ld_hit || (st_take && same_word))); // R8
endmodule

bind spec_store_cache ssc_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINES(LINES)) u_chk (.*);

// File: tb/tb_spec_store_cache.sv
module tb_spec_store_cache;
  logic        clk;
  logic        rst_n;
  logic        ahead_mode, flush, st_en, st_poison, ld_en;
  logic [31:0] st_addr, st_data, ld_addr, dc_data;
  logic        ld_hit, ld_poison;
  logic [31:0] ld_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  spec_store_cache dut (.*);

  initial clk = 1'b0;
  always #2 clk = ~clk;

  typedef struct packed {
    bit        mode;
    bit        fl;
    bit        st;
    bit [31:0] sa;
    bit [31:0] sd;
    bit        sp;
    bit        ld;
    bit [31:0] la;
    bit [31:0] dc;
    bit        eh;
    bit [31:0] ed;
    bit        ep;
    bit [7:0]  req;
  } vec_t;

  localparam bit [31:0] A = 32'h0000_1004;  // index 1
  localparam bit [31:0] B = 32'h0000_2004;  // index 1, other tag
  localparam bit [31:0] C = 32'h0000_0040;  // index 0

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{1'b0,1'b0,1'b1,A,32'h1111_1111,1'b0,1'b1,A,32'hD000_0000,1'b0,32'hD000_0000,1'b0,8'd2}, // R2 normal
    '{1'b1,1'b0,1'b0,A,32'h0,1'b0,1'b1,A,32'hD000_0001,1'b0,32'hD000_0001,1'b0,8'd2},         // R2 no write
    '{1'b1,1'b0,1'b1,A,32'hAAAA_0001,1'b0,1'b1,C,32'hD000_0002,1'b0,32'hD000_0002,1'b0,8'd6}, // R6 miss
    '{1'b1,1'b0,1'b0,A,32'h0,1'b0,1'b1,A,32'hD000_0003,1'b1,32'hAAAA_0001,1'b0,8'd3},         // R3
    '{1'b1,1'b0,1'b1,A,32'hBBBB_0002,1'b1,1'b0,A,32'hD000_0004,1'b0,32'hD000_0004,1'b0,8'd11}, // R11
    '{1'b1,1'b0,1'b0,A,32'h0,1'b0,1'b1,A,32'hD000_0005,1'b1,32'hBBBB_0002,1'b1,8'd4},         // R4
    '{1'b1,1'b0,1'b1,A,32'hCCCC_0003,1'b0,1'b1,A,32'hD000_0006,1'b1,32'hCCCC_0003,1'b0,8'd9}, // R9
    '{1'b1,1'b0,1'b0,A,32'h0,1'b0,1'b1,A+3,32'hD000_0007,1'b1,32'hCCCC_0003,1'b0,8'd5},       // R5 / R10
    '{1'b1,1'b0,1'b1,B,32'hDDDD_0004,1'b0,1'b1,A,32'hD000_0008,1'b1,32'hCCCC_0003,1'b0,8'd6}, // R6 override
    '{1'b1,1'b0,1'b0,A,32'h0,1'b0,1'b1,A,32'hD000_0009,1'b0,32'hD000_0009,1'b0,8'd7},         // R7
    '{1'b1,1'b0,1'b0,A,32'h0,1'b0,1'b1,B,32'hD000_000A,1'b1,32'hDDDD_0004,1'b0,8'd7},         // R7
    '{1'b1,1'b0,1'b1,C,32'h0000_0005,1'b1,1'b1,C,32'hD000_000B,1'b1,32'h0000_0005,1'b1,8'd9}, // R9
    '{1'b0,1'b0,1'b0,A,32'h0,1'b0,1'b1,B,32'hD000_000C,1'b0,32'hD000_000C,1'b0,8'd2},         // R2
    '{1'b1,1'b1,1'b1,A,32'hEEEE_0006,1'b0,1'b1,B,32'hD000_000D,1'b1,32'hDDDD_0004,1'b0,8'd8}, // R8
    '{1'b1,1'b0,1'b0,A,32'h0,1'b0,1'b1,B,32'hD000_000E,1'b0,32'hD000_000E,1'b0,8'd8},         // R8
    '{1'b1,1'b0,1'b0,A,32'h0,1'b0,1'b1,A,32'hD000_000F,1'b0,32'hD000_000F,1'b0,8'd8},         // R8
    '{1'b1,1'b0,1'b0,A,32'h0,1'b0,1'b1,C,32'hD000_0010,1'b0,32'hD000_0010,1'b0,8'd8}          // R8
  };

  task automatic check(input bit [7:0] req, input bit eh, input bit [31:0] ed, input bit ep);
    checks++;
    if (ld_hit !== eh || ld_data !== ed || ld_poison !== ep) begin
      fails++;
      $display("FAIL R%0d: hit=%0b data=%h poison=%0b, expected hit=%0b data=%h poison=%0b",
               req, ld_hit, ld_data, ld_poison, eh, ed, ep);
    end
  endtask

  task automatic drive(input vec_t v);
    @(negedge clk);
    ahead_mode = v.mode; flush = v.fl; st_en = v.st; st_addr = v.sa;
    st_data = v.sd; st_poison = v.sp; ld_en = v.ld; ld_addr = v.la; dc_data = v.dc;
    #1;
    check(v.req, v.eh, v.ed, v.ep);
  endtask

  function automatic vec_t mk(bit st, bit [31:0] sa, bit [31:0] sd, bit ld, bit [31:0] la,
                              bit [31:0] dc, bit eh, bit [31:0] ed, bit [7:0] req);
    vec_t v;
    v = '{1'b1,1'b0,st,sa,sd,1'b0,ld,la,dc,eh,ed,1'b0,req};
    return v;
  endfunction

  initial begin
    rst_n = 1'b0; ahead_mode = 0; flush = 0; st_en = 0; st_poison = 0; ld_en = 0;
    st_addr = '0; st_data = '0; ld_addr = '0; dc_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: empty after reset
    drive(mk(1'b0, 0, 0, 1'b1, A, 32'h5A5A_0000, 1'b0, 32'h5A5A_0000, 8'd1));

    for (int i = 0; i < NV; i++) drive(VECS[i]);

    // R10: fill every index, then read each one back
    for (int i = 0; i < 16; i++)
      drive(mk(1'b1, 32'h0000_3000 + 32'(i*4), 32'hF000_0000 + 32'(i), 1'b0, 0, 32'h1, 1'b0, 32'h1, 8'd10));
    for (int i = 0; i < 16; i++)
      drive(mk(1'b0, 0, 0, 1'b1, 32'h0000_3000 + 32'(i*4) + 32'(i % 4), 32'h2, 1'b1,
               32'hF000_0000 + 32'(i), 8'd10));

    // R1: reset in mid-run empties the entries
    @(negedge clk); rst_n = 1'b0; ahead_mode = 0; st_en = 0; ld_en = 0;
    @(negedge clk); rst_n = 1'b1;
    drive(mk(1'b0, 0, 0, 1'b1, 32'h0000_3008, 32'h7777_0000, 1'b0, 32'h7777_0000, 8'd1));

    // R7: conflict on index 0 after a fresh fill
    drive(mk(1'b1, C, 32'h0000_00C1, 1'b0, 0, 32'h3, 1'b0, 32'h3, 8'd7));
    drive(mk(1'b1, 32'h0000_0080, 32'h0000_00C2, 1'b1, C, 32'h4, 1'b1, 32'h0000_00C1, 8'd7));
    drive(mk(1'b0, 0, 0, 1'b1, C, 32'h5, 1'b0, 32'h5, 8'd7));

    done = 1;
    @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule